// File: doc/BRIEF.md
# Thread Block Admission Dispatcher

This block decides which pending thread blocks become resident on a single multiprocessor. Requests arrive in order on a valid/ready queue. Each request gives the thread count of a block and the registers each of its threads uses. The dispatcher admits queued blocks one per cycle while they fit under three occupancy budgets: resident blocks, resident threads, and total registers (threads times registers per thread). It gives each admitted block a slot id on a one-cycle dispatch pulse.

The dispatcher works in events. An event ends at the first queued block that does not fit, or when the queue runs empty while at least one block is resident. It never skips past a block that does not fit. Once an event has ended, it admits nothing until every block of that event has reported completion by slot id. The completion that empties the multiprocessor also zeroes the budgets, and the next event starts on the following cycle. A block that could never fit, even on an empty multiprocessor, is accepted and dropped with an error pulse, so it cannot block the queue forever.

Top module: `blk_dispatch`

## Requirements
- R1: No more than MAX_BLK (8) blocks are admitted within one event. The next block waits until the event has drained.
- R2: The threads of all blocks admitted in one event never total more than MAX_THR (768).
- R3: The sum of threads × registers-per-thread over the blocks admitted in one event never exceeds MAX_REG (16384). A 512-thread block at 32 registers per thread is therefore the only block in its event.
- R4: Blocks are admitted strictly in queue order. When the head does not fit, req_ready_o stays low for it, the event closes, and no later request is considered.
- R5: While an event is draining, req_ready_o is low. An event closes when the head does not fit, or when req_valid_i is low while at least one block is counted.
- R6: Each admitted block produces disp_valid_o high for exactly the cycle after its handshake. disp_slot_o then carries the lowest-numbered slot (0 to MAX_BLK-1) that was not resident in the handshake cycle.
- R7: A request with more than MAX_THR threads, or with threads × registers-per-thread above MAX_REG, is accepted on its own in the current event, if that event is still admitting. It raises err_o for the cycle after its handshake. It is never dispatched and does not count against the budgets.
- R8: The completion that leaves no block of a draining event resident zeroes all three budgets. A fitting head is admitted in the very next cycle.
- R9: A completion naming a slot that is not resident has no effect.
- R10: After reset, disp_valid_o and err_o are low, all budgets are empty, and the first admitted block receives slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Queue head present |
| req_ready_o | output | 1 | Queue head taken this cycle (admitted or dropped) |
| req_threads_i | input | THR_W (11) | Thread count of the head block |
| req_rpt_i | input | RPT_W (8) | Registers per thread of the head block |
| done_valid_i | input | 1 | A resident block has finished |
| done_slot_i | input | SLOT_W (3) | Slot id of the finished block |
| disp_valid_o | output | 1 | Block dispatched (one cycle after handshake) |
| disp_slot_o | output | SLOT_W (3) | Slot id given to the dispatched block |
| err_o | output | 1 | Oversized block dropped (one cycle after handshake) |

## Verification
The bench builds the dispatcher with its default budgets: 8 blocks, 768 threads and 16384 registers, with 11-bit thread and 8-bit register-per-thread fields. With these settings, small 32-thread blocks run into the block cap, 512 + 384 threads run into the thread cap, and a 512×32 block fills the register file by itself. The field widths also allow oversized requests on both the thread axis and the register axis. Random request sizes with random completion timing cover events that close on an empty queue, stray completions, and blocks that finish before their event has closed.

// File: rtl/bd_pkg.sv
package bd_pkg;
  parameter int unsigned DEF_MAX_BLK = 8;
  parameter int unsigned DEF_MAX_THR = 768;
  parameter int unsigned DEF_MAX_REG = 16384;
  parameter int unsigned DEF_THR_W   = 11;
  parameter int unsigned DEF_RPT_W   = 8;

  typedef enum logic {
    ST_FILL  = 1'b0,
    ST_DRAIN = 1'b1
  } disp_state_e;
endpackage

// File: rtl/bd_budget.sv
module bd_budget #(
  parameter int unsigned MAX_BLK = bd_pkg::DEF_MAX_BLK,
  parameter int unsigned MAX_THR = bd_pkg::DEF_MAX_THR,
  parameter int unsigned MAX_REG = bd_pkg::DEF_MAX_REG,
  parameter int unsigned THR_W   = bd_pkg::DEF_THR_W,
  parameter int unsigned RPT_W   = bd_pkg::DEF_RPT_W,
  localparam int unsigned BLK_W  = $clog2(MAX_BLK + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [THR_W-1:0] thr_i,
  input  logic [RPT_W-1:0] rpt_i,
  input  logic             admit_i,
  input  logic             clear_i,
  output logic             fits_o,
  output logic             over_o,
  output logic [BLK_W-1:0] cnt_blk_o
);
  localparam int unsigned NEED_W = THR_W + RPT_W;
  localparam int unsigned SUM_W  = NEED_W + 1;
  localparam int unsigned CTHR_W = $clog2(MAX_THR + 1);
  localparam int unsigned CREG_W = $clog2(MAX_REG + 1);

  logic [BLK_W-1:0]  cnt_blk_q;
  logic [CTHR_W-1:0] cnt_thr_q;
  logic [CREG_W-1:0] cnt_reg_q;
  logic [NEED_W-1:0] need;
  logic [SUM_W-1:0]  thr_sum, reg_sum;

  assign need    = NEED_W'(thr_i) * NEED_W'(rpt_i);
  assign thr_sum = SUM_W'(cnt_thr_q) + SUM_W'(thr_i);
  assign reg_sum = SUM_W'(cnt_reg_q) + SUM_W'(need);

  // oversize: could not fit even on an empty multiprocessor
  assign over_o = (SUM_W'(thr_i) > SUM_W'(MAX_THR)) || (SUM_W'(need) > SUM_W'(MAX_REG));
  assign fits_o = (cnt_blk_q < BLK_W'(MAX_BLK)) &&
                  (thr_sum <= SUM_W'(MAX_THR)) &&
                  (reg_sum <= SUM_W'(MAX_REG));
  assign cnt_blk_o = cnt_blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_blk_q <= '0;
      cnt_thr_q <= '0;
      cnt_reg_q <= '0;
    end else if (clear_i) begin
      cnt_blk_q <= '0;
      cnt_thr_q <= '0;
      cnt_reg_q <= '0;
    end else if (admit_i) begin
      cnt_blk_q <= cnt_blk_q + BLK_W'(1);
      cnt_thr_q <= cnt_thr_q + CTHR_W'(thr_i);
      cnt_reg_q <= cnt_reg_q + CREG_W'(need);
    end
  end

  p_blk_cap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_blk_q <= BLK_W'(MAX_BLK));
  p_thr_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_thr_q <= CTHR_W'(MAX_THR));
  p_reg_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_reg_q <= CREG_W'(MAX_REG));
  p_clear_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_blk_q == '0) && (cnt_thr_q == '0) && (cnt_reg_q == '0));
endmodule

// File: rtl/bd_slot_pool.sv
module bd_slot_pool #(
  parameter int unsigned MAX_BLK = bd_pkg::DEF_MAX_BLK,
  localparam int unsigned SLOT_W = (MAX_BLK > 1) ? $clog2(MAX_BLK) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic              done_valid_i,
  input  logic [SLOT_W-1:0] done_slot_i,
  output logic [SLOT_W-1:0] free_slot_o,
  output logic              free_ok_o,
  output logic              last_o,
  output logic [MAX_BLK-1:0] busy_o
);
  logic [MAX_BLK-1:0] busy_q;
  logic [MAX_BLK-1:0] done_mask;
  logic [MAX_BLK-1:0] alloc_mask;

  // lowest-index free slot
  always_comb begin
    free_slot_o = '0;
    free_ok_o   = 1'b0;
    for (int i = MAX_BLK - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        free_slot_o = SLOT_W'(i);
        free_ok_o   = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < MAX_BLK; g++) begin : g_slot
    assign done_mask[g]  = done_valid_i && (done_slot_i == SLOT_W'(g));
    assign alloc_mask[g] = alloc_i && (free_slot_o == SLOT_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) busy_q[g] <= 1'b0;
      else         busy_q[g] <= (busy_q[g] && !done_mask[g]) || alloc_mask[g];
    end
  end

  assign last_o = ((busy_q & ~done_mask) == '0);
  assign busy_o = busy_q;

  p_stray_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_i && !busy_q[done_slot_i] && !alloc_i) |=> $stable(busy_q));
  p_alloc_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> ($countones(busy_q) >= 1));
endmodule

// File: rtl/blk_dispatch.sv
module blk_dispatch #(
  parameter int unsigned MAX_BLK = bd_pkg::DEF_MAX_BLK,
  parameter int unsigned MAX_THR = bd_pkg::DEF_MAX_THR,
  parameter int unsigned MAX_REG = bd_pkg::DEF_MAX_REG,
  parameter int unsigned THR_W   = bd_pkg::DEF_THR_W,
  parameter int unsigned RPT_W   = bd_pkg::DEF_RPT_W,
  localparam int unsigned SLOT_W = (MAX_BLK > 1) ? $clog2(MAX_BLK) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [THR_W-1:0]  req_threads_i,
  input  logic [RPT_W-1:0]  req_rpt_i,
  input  logic              done_valid_i,
  input  logic [SLOT_W-1:0] done_slot_i,
  output logic              disp_valid_o,
  output logic [SLOT_W-1:0] disp_slot_o,
  output logic              err_o
);
  import bd_pkg::*;
  localparam int unsigned BLK_W = $clog2(MAX_BLK + 1);

  disp_state_e        state_q, state_d;
  logic               fits, over, free_ok, last, admit, drop, clear;
  logic [BLK_W-1:0]   cnt_blk;
  logic [SLOT_W-1:0]  free_slot;
  logic [MAX_BLK-1:0] busy;

  bd_budget #(
    .MAX_BLK(MAX_BLK), .MAX_THR(MAX_THR), .MAX_REG(MAX_REG),
    .THR_W(THR_W), .RPT_W(RPT_W)
  ) u_budget (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .thr_i    (req_threads_i),
    .rpt_i    (req_rpt_i),
    .admit_i  (admit),
    .clear_i  (clear),
    .fits_o   (fits),
    .over_o   (over),
    .cnt_blk_o(cnt_blk)
  );

  bd_slot_pool #(.MAX_BLK(MAX_BLK)) u_pool (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (admit),
    .done_valid_i(done_valid_i),
    .done_slot_i (done_slot_i),
    .free_slot_o (free_slot),
    .free_ok_o   (free_ok),
    .last_o      (last),
    .busy_o      (busy)
  );

  assign req_ready_o = (state_q == ST_FILL) && (over || (fits && free_ok));
  assign admit = req_valid_i && req_ready_o && !over;
  assign drop  = req_valid_i && req_ready_o && over;
  assign clear = (state_q == ST_DRAIN) && last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FILL: begin
        if (req_valid_i && !req_ready_o)              state_d = ST_DRAIN;
        else if (!req_valid_i && (cnt_blk != '0))     state_d = ST_DRAIN;
      end
      ST_DRAIN: if (last)                              state_d = ST_FILL;
      default:                                         state_d = ST_FILL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_FILL;
      disp_valid_o <= 1'b0;
      disp_slot_o  <= '0;
      err_o        <= 1'b0;
    end else begin
      state_q      <= state_d;
      disp_valid_o <= admit;
      err_o        <= drop;
      if (admit) disp_slot_o <= free_slot;
    end
  end

  p_drain_closed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN) |-> !req_ready_o);
  p_order_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o && state_q == ST_FILL) |=> (state_q == ST_DRAIN));
  p_disp_next_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !over) |=> disp_valid_o);
  p_slot_resident_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> busy[disp_slot_o]);
  p_drop_no_disp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !disp_valid_o);
  p_refill_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN && last) |=> (cnt_blk == '0 && state_q == ST_FILL));
endmodule

// File: tb/blk_dispatch_test.sv
`timescale 1ns/1ps
module blk_dispatch_test;
  localparam int NB = 8, NT = 768, NR = 16384;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       req_valid = 1'b0, done_valid = 1'b0;
  logic [10:0] req_thr = '0;
  logic [7:0]  req_rpt = '0;
  logic [2:0]  done_slot = '0;
  logic       req_ready, disp_valid, err;
  logic [2:0] disp_slot;

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench model of the requirements
  bit       m_drain = 0;
  int       m_blk = 0, m_thr = 0, m_reg = 0;
  bit [7:0] m_busy = '0;
  bit       e_dv = 0, e_err = 0;
  int       e_slot = 0;

  always #10 clk = ~clk;

  blk_dispatch uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_threads_i(req_thr), .req_rpt_i(req_rpt),
    .done_valid_i(done_valid), .done_slot_i(done_slot),
    .disp_valid_o(disp_valid), .disp_slot_o(disp_slot), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lowest_free(input bit [7:0] b);
    for (int i = 0; i < NB; i++) if (!b[i]) return i;
    return 0;
  endfunction

  function automatic bit is_over(input int t, input int r);
    return (t > NT) || (t * r > NR);
  endfunction

  function automatic bit does_fit(input int t, input int r);
    return (m_blk < NB) && (m_thr + t <= NT) && (m_reg + t * r <= NR);
  endfunction

  // one clock: check last cycle's registered outputs, drive, check ready, step model
  task automatic cyc(input bit v, input int t, input int r, input bit dv, input int ds,
                     input string tag, output bit acc);
    bit over, fit, rdy;
    bit [7:0] dmask, amask;
    @(negedge clk);
    chk(disp_valid == e_dv, "R6 disp_valid", disp_valid, e_dv);
    if (e_dv) chk(disp_slot == e_slot, "R6 disp_slot", disp_slot, e_slot);
    chk(err == e_err, "R7 err", err, e_err);
    req_valid = v; req_thr = 11'(t); req_rpt = 8'(r);
    done_valid = dv; done_slot = 3'(ds);
    #1;
    over = is_over(t, r);
    fit  = does_fit(t, r);
    rdy  = !m_drain && (over || fit);
    chk(req_ready == rdy, tag, req_ready, rdy);
    acc = v && rdy;
    dmask = dv ? (8'b1 << ds) : 8'b0;
    amask = '0;
    e_dv = 0; e_err = 0;
    if (!m_drain) begin
      if (v && over) e_err = 1;
      else if (v && fit) begin
        e_dv = 1; e_slot = lowest_free(m_busy);
        amask = 8'b1 << e_slot;
        m_blk++; m_thr += t; m_reg += t * r;
      end else if (v || m_blk > 0) m_drain = 1;
    end else if ((m_busy & ~dmask) == 0) begin
      m_drain = 0; m_blk = 0; m_thr = 0; m_reg = 0;
    end
    m_busy = (m_busy & ~dmask) | amask;
  endtask

  task automatic drain_all(input string tag);
    bit a;
    for (int i = 0; i < NB; i++)
      if (m_busy[i]) cyc(0, 0, 0, 1, i, tag, a);
    cyc(0, 0, 0, 0, 0, tag, a);
  endtask

  initial begin
    bit a;
    int hold_t, hold_r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(disp_valid == 0, "R10 disp_valid reset", disp_valid, 0);
    chk(err == 0, "R10 err reset", err, 0);
    rst_n = 1'b1;

    // R10 / R1: eight 32x1 blocks, ninth held off
    for (int i = 0; i < 8; i++) cyc(1, 32, 1, 0, 0, "R1 admit small", a);
    cyc(1, 32, 1, 0, 0, "R1 ninth block refused", a);
    chk(a == 0, "R1 ninth accepted", a, 0);
    // R5: completions one by one, ready stays low until the last
    for (int i = 7; i >= 1; i--) cyc(1, 32, 1, 1, i, "R5 draining", a);
    cyc(1, 32, 1, 1, 0, "R8 last completion", a);
    cyc(1, 32, 1, 0, 0, "R8 refill next cycle", a);
    chk(a == 1, "R8 refill accepted", a, 1);
    cyc(0, 0, 0, 0, 0, "R5 empty queue closes", a);
    drain_all("R5 drain");

    // R3: 512x32 fills the register file alone
    cyc(1, 512, 32, 0, 0, "R3 big block", a);
    cyc(1, 32, 1, 0, 0, "R3 next refused", a);
    chk(a == 0, "R3 second block", a, 0);
    drain_all("R3 drain");

    // R2 / R4: 512 + 384 threads overflow; no skipping to a smaller one
    cyc(1, 512, 1, 0, 0, "R2 first", a);
    cyc(1, 384, 1, 0, 0, "R4 head does not fit", a);
    chk(a == 0, "R4 no skip", a, 0);
    cyc(1, 256, 1, 0, 0, "R4 later request ignored", a);
    chk(a == 0, "R4 later request", a, 0);
    drain_all("R2 drain");

    // R7: oversize on threads and on registers
    cyc(1, 1024, 1, 0, 0, "R7 too many threads", a);
    cyc(1, 600, 30, 0, 0, "R7 too many registers", a);
    cyc(1, 768, 21, 0, 0, "R7 exact limits", a);
    // R9: stray completion for slot 5 while only slot 0 resident
    cyc(0, 0, 0, 1, 5, "R9 stray completion", a);
    cyc(0, 0, 0, 1, 3, "R9 stray in drain", a);
    drain_all("R9 drain");

    // random traffic
    hold_t = 32; hold_r = 4;
    for (int n = 0; n < 4000; n++) begin
      bit v, dv;
      int ds, k;
      v  = ($urandom % 8) != 0;
      dv = 0; ds = 0;
      if (m_busy != 0 && ($urandom % 3) == 0) begin
        do ds = $urandom % NB; while (!m_busy[ds]);
        dv = 1;
      end else if (($urandom % 25) == 0) begin
        ds = $urandom % NB; dv = 1;
      end
      cyc(v, hold_t, hold_r, dv, ds, "R4 random ready", a);
      if (a) begin
        k = $urandom % 20;
        if (k == 0)      begin hold_t = 769 + $urandom % 1000; hold_r = 1; end
        else if (k == 1) begin hold_t = 256 + $urandom % 500; hold_r = 40 + $urandom % 200; end
        else begin hold_t = 32 * (1 + $urandom % 16); hold_r = 1 + $urandom % 40; end
        if (is_over(hold_t, hold_r) && k > 1) hold_r = 1;
      end
    end
    cyc(0, 0, 0, 0, 0, "R6 final", a);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule